// File: doc/BRIEF.md
# Peak-Tracking Receive Level Measure and Bit Slicer

This block sits after the receive low-pass filter of a baseband modem. It follows the positive and the negative signal peaks of the signed filtered samples in two fixed-point registers, forms a decision level from them and decides one data bit at every mid-bit strobe. The strobe comes from a separate clock-recovery block. The decision level moves bit by bit against intersymbol interference. The size of that move depends on a filter-bandwidth select input and on the previous decision.

A level-acquire input and an active-low freeze input select how the trackers behave. A rising acquire edge starts a short clamp of one bit duration that pulls both registers toward half the input. While acquire stays high, the registers act as fast peak catchers. When acquire drops and freeze_n is high, they settle into slow averaging peak detection. With both inputs low, they coast and only leak very slowly toward the zero bias level once per bit, so that a fade can be bridged. A powersave input forces the data output low.

Top module: `lvl_slicer_top`

## Requirements
- R1: A synchronous active-low reset (`rst_n` = 0 at a rising clock edge) clears both peak outputs, `rx_bit` and the previous-decision history to 0, and it leaves the sequencer out of clamp.
- R2: A 0-to-1 change of `lvl_acq` starts clamp mode. Clamp covers SPB (default 8) enabled samples, counting the sample in the cycle of the rise. On each such sample, each register r (signed, FRAC = 11 fraction bits) becomes r + ((s/2 − r) >>> 2), where s is the sample scaled by 2^11 and s/2 is an arithmetic shift right by one.
- R3: While `lvl_acq` stays 1 after clamp, fast peak mode applies on each enabled sample. The high register becomes r + ((s − r) >>> 2) only when s > r. The low register does the same only when s < r. Otherwise they do not change.
- R4: With `lvl_acq` = 0 and `freeze_n` = 1, averaging mode applies on each enabled sample. A register that the sample passes beyond becomes r + ((s − r) >>> 6). Any other register becomes r − (r >>> 10).
- R5: With `lvl_acq` = 0 and `freeze_n` = 0, hold mode applies. Both registers keep their values except on each `mid_stb` cycle, where each register becomes r − (r >>> 11).
- R6: `freeze_n` has no effect while `lvl_acq` is 1.
- R7: On a cycle with both `mid_stb` and `smp_en` set, the decision level is mid + isi if the previous decision was 0, and mid − isi if it was 1. Here mid = (hi + lo) >>> 1 and isi = (hi − lo) >>> 3 with `bt_wide` = 0, or >>> 4 with `bt_wide` = 1. The level uses the register values from before that cycle's update. The result appears on `rx_bit` in the next cycle and is held until the next decision.
- R8: A scaled sample strictly below the decision level decodes as 1. A sample equal to or above it decodes as 0.
- R9: `rx_psave` = 1 makes `rx_bit` 0 from the next cycle onward, with or without a strobe. The decision history still records each new raw decision.
- R10: `pk_hi` and `pk_lo` are the integer parts of the registers (arithmetic shift right by 11), SW bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp | input | SW (12) | Signed filtered receive sample, bias at 0 |
| smp_en | input | 1 | Sample valid |
| mid_stb | input | 1 | Mid-bit strobe from clock recovery |
| lvl_acq | input | 1 | Level-acquire control |
| freeze_n | input | 1 | 0 freezes the trackers when not acquiring |
| bt_wide | input | 1 | 1 selects the wider-band ISI term (/16), 0 the narrow one (/8) |
| rx_psave | input | 1 | Receive powersave, forces rx_bit to 0 |
| rx_bit | output | 1 | Decided data bit |
| pk_hi | output | SW (12) | Integer part of the positive peak register |
| pk_lo | output | SW (12) | Integer part of the negative peak register |

## Verification
A wrong register value shows on `pk_hi` or `pk_lo` in the cycle right after the enabled sample that caused it. Fractional-only errors appear there only after they have added up to one integer step. A wrong mode (clamp too long or too short, or a freeze obeyed during acquire) moves the registers with the wrong step size, so the port values drift away from the expected values within one bit. An error in the level or in the ISI sign shows on `rx_bit` only when a strobed sample falls between the correct and the wrong level. For this reason the bench uses sample amplitudes and DC offsets that put strobed samples close to the decision level.

// File: rtl/lvl_pkg.sv
// Shared types for the level-measure and slicer block.
// Assumes: one mode value per cycle, decided by lvl_mode_seq.
package lvl_pkg;
    typedef enum logic [1:0] {
        LM_CLAMP = 2'd0,
        LM_FAST  = 2'd1,
        LM_AVG   = 2'd2,
        LM_HOLD  = 2'd3
    } lvl_mode_e;
endpackage

// File: rtl/lvl_mode_seq.sv
// Mode sequencer: turns the acquire and freeze controls into one of four tracker modes.
// A rising acquire edge gives SPB enabled samples of clamp, then fast peak while acquire
// stays high. With acquire low, freeze_n picks averaging (1) or hold (0).
// Assumes: lvl_acq and freeze_n are synchronous to clk.
module lvl_mode_seq
    import lvl_pkg::*;
#(
    parameter int SPB = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sample_en,
    input  logic      acq,
    input  logic      freeze_n,
    output lvl_mode_e mode
);
    localparam int CW = $clog2(SPB + 1);

    logic          acq_q;
    logic [CW-1:0] clamp_left;
    logic          acq_rise;
    logic          in_clamp;

    assign acq_rise = acq && !acq_q;
    assign in_clamp = acq && (acq_rise || (clamp_left != '0));

    // Purpose: remember the previous acquire level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) acq_q <= 1'b0;
        else        acq_q <= acq;
    end

    // Purpose: count the enabled samples that remain in clamp after the acquire rise.
    always_ff @(posedge clk) begin
        if (!rst_n || !acq)
            clamp_left <= '0;
        else if (acq_rise)
            clamp_left <= sample_en ? CW'(SPB - 1) : CW'(SPB);
        else if (sample_en && (clamp_left != '0))
            clamp_left <= clamp_left - 1'b1;
    end

    // Purpose: select the tracker mode for this cycle.
    always_comb begin
        if (acq)           mode = in_clamp ? LM_CLAMP : LM_FAST;
        else if (freeze_n) mode = LM_AVG;
        else               mode = LM_HOLD;
    end

    // R2: an acquire rise always starts in clamp
    p_clamp_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acq && !$past(acq)) |-> (mode == LM_CLAMP));
    // R6: while acquiring, freeze_n never selects averaging or hold
    p_freeze_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acq |-> (mode == LM_CLAMP || mode == LM_FAST));
    // R2: the clamp window never exceeds one bit of samples
    p_clamp_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_left <= CW'(SPB));
endmodule

// File: rtl/lvl_peak_trk.sv
// One peak tracker. POS_SIDE = 1 follows positive peaks, POS_SIDE = 0 negative peaks.
// The register has FRAC fraction bits. Clamp, fast, averaging and hold steps are arithmetic
// shifts. Assumes: sample magnitudes fit SW bits, and RW leaves two bits of headroom.
module lvl_peak_trk
    import lvl_pkg::*;
#(
    parameter int SW           = 12,
    parameter int FRAC         = 11,
    parameter int RW           = SW + FRAC + 2,
    parameter bit POS_SIDE     = 1'b1,
    parameter int CLAMP_SH     = 2,
    parameter int FAST_SH      = 2,
    parameter int AVG_UP_SH    = 6,
    parameter int AVG_LEAK_SH  = 10,
    parameter int HOLD_LEAK_SH = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_en,
    input  logic                 strobe,
    input  lvl_mode_e            mode,
    input  logic signed [RW-1:0] s_ext,
    output logic signed [RW-1:0] pk
);
    logic signed [RW-1:0] err;
    logic signed [RW-1:0] half;
    logic signed [RW-1:0] nxt;
    logic                 beyond;

    assign err    = s_ext - pk;
    assign half   = s_ext >>> 1;
    assign beyond = POS_SIDE ? (err > 0) : (err < 0);

    // Purpose: compute the next register value for the current mode.
    always_comb begin
        nxt = pk;
        unique case (mode)
            LM_CLAMP: if (sample_en) nxt = pk + ((half - pk) >>> CLAMP_SH);
            LM_FAST:  if (sample_en && beyond) nxt = pk + (err >>> FAST_SH);
            LM_AVG:   if (sample_en)
                          nxt = beyond ? (pk + (err >>> AVG_UP_SH))
                                       : (pk - (pk >>> AVG_LEAK_SH));
            LM_HOLD:  if (strobe) nxt = pk - (pk >>> HOLD_LEAK_SH);
            default:  nxt = pk;
        endcase
    end

    // Purpose: hold the peak register.
    always_ff @(posedge clk) begin
        if (!rst_n) pk <= '0;
        else        pk <= nxt;
    end

    // R5: in hold mode the register is stable between strobes
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_HOLD && !strobe) |=> $stable(pk));
    // R3: fast mode only moves the register outward
    p_fast_outward_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_FAST) |=> (POS_SIDE ? (pk >= $past(pk)) : (pk <= $past(pk))));
endmodule

// File: rtl/lvl_slicer.sv
// Bit slicer: compares the strobed sample with a level taken from the two peaks and
// shifted by an ISI term whose sign follows the previous decision.
// Assumes: the strobe is valid only together with sample_en. Peak inputs are the
// register values before this cycle's update.
module lvl_slicer #(
    parameter int RW            = 25,
    parameter int ISI_NARROW_SH = 3,
    parameter int ISI_WIDE_SH   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_en,
    input  logic                 strobe,
    input  logic                 bt_wide,
    input  logic                 psave,
    input  logic signed [RW-1:0] s_ext,
    input  logic signed [RW-1:0] hi,
    input  logic signed [RW-1:0] lo,
    output logic                 rx_bit
);
    logic signed [RW-1:0] mid;
    logic signed [RW-1:0] spread;
    logic signed [RW-1:0] isi;
    logic signed [RW-1:0] level;
    logic                 prev_bit;
    logic                 raw_bit;
    logic                 decide;

    assign decide = strobe && sample_en;

    // Purpose: form the ISI-shifted decision level and the raw decision.
    always_comb begin
        mid     = (hi + lo) >>> 1;
        spread  = hi - lo;
        isi     = bt_wide ? (spread >>> ISI_WIDE_SH) : (spread >>> ISI_NARROW_SH);
        level   = prev_bit ? (mid - isi) : (mid + isi);
        raw_bit = (s_ext < level);
    end

    // Purpose: keep the decision history and drive the gated output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_bit <= 1'b0;
            rx_bit   <= 1'b0;
        end else begin
            if (decide) prev_bit <= raw_bit;
            if (psave)       rx_bit <= 1'b0;
            else if (decide) rx_bit <= raw_bit;
        end
    end

    // R9: powersave forces the data low in the next cycle
    p_psave_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        psave |=> !rx_bit);
    // R7: without a strobe or powersave the data output holds
    p_data_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!decide && !psave) |=> $stable(rx_bit));
endmodule

// File: rtl/lvl_slicer_top.sv
// Top of the receive level-measure and slicer block. Scales the samples to fixed point,
// runs the mode sequencer, two peak trackers (made by a generate loop) and the slicer.
// Assumes: mid_stb comes from an external clock-recovery block, once per bit.
module lvl_slicer_top
    import lvl_pkg::*;
#(
    parameter int SW   = 12,
    parameter int FRAC = 11,
    parameter int SPB  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] smp,
    input  logic          smp_en,
    input  logic          mid_stb,
    input  logic          lvl_acq,
    input  logic          freeze_n,
    input  logic          bt_wide,
    input  logic          rx_psave,
    output logic          rx_bit,
    output logic [SW-1:0] pk_hi,
    output logic [SW-1:0] pk_lo
);
    localparam int RW       = SW + FRAC + 2;
    localparam int CLAMP_SH = (SPB > 2) ? ($clog2(SPB) - 1) : 1;

    logic signed [RW-1:0] s_ext;
    logic signed [RW-1:0] pk_reg [2];
    lvl_mode_e            mode;

    assign s_ext = {{(RW-SW-FRAC){smp[SW-1]}}, smp, {FRAC{1'b0}}};

    lvl_mode_seq #(.SPB(SPB)) u_seq (
        .clk(clk), .rst_n(rst_n), .sample_en(smp_en),
        .acq(lvl_acq), .freeze_n(freeze_n), .mode(mode)
    );

    // index 0 tracks the positive peak, index 1 the negative peak
    for (genvar g = 0; g < 2; g++) begin : g_trk
        lvl_peak_trk #(
            .SW(SW), .FRAC(FRAC), .RW(RW), .POS_SIDE(g == 0), .CLAMP_SH(CLAMP_SH)
        ) u_trk (
            .clk(clk), .rst_n(rst_n), .sample_en(smp_en), .strobe(mid_stb),
            .mode(mode), .s_ext(s_ext), .pk(pk_reg[g])
        );
    end

    lvl_slicer #(.RW(RW)) u_slc (
        .clk(clk), .rst_n(rst_n), .sample_en(smp_en), .strobe(mid_stb),
        .bt_wide(bt_wide), .psave(rx_psave), .s_ext(s_ext),
        .hi(pk_reg[0]), .lo(pk_reg[1]), .rx_bit(rx_bit)
    );

    assign pk_hi = pk_reg[0][FRAC +: SW];
    assign pk_lo = pk_reg[1][FRAC +: SW];

    // R1: outputs are zero right after a reset cycle
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pk_hi == '0 && pk_lo == '0 && !rx_bit));
endmodule

// File: tb/test_lvl_slicer_top.sv
// Scoreboard bench. The driver sets inputs at the falling edge, steps a model built from the
// requirements and pushes the expected outputs. The monitor pops and compares after each
// rising edge.
module test_lvl_slicer_top;
    localparam int SW = 12, FRAC = 11, SPB = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0, smp_en = 1'b0, mid_stb = 1'b0, lvl_acq = 1'b0;
    logic          freeze_n = 1'b1, bt_wide = 1'b0, rx_psave = 1'b0;
    logic [SW-1:0] smp = '0;
    logic          rx_bit;
    logic [SW-1:0] pk_hi, pk_lo;

    lvl_slicer_top #(.SW(SW), .FRAC(FRAC), .SPB(SPB)) i_lvl_slicer_top (
        .clk(clk), .rst_n(rst_n), .smp(smp), .smp_en(smp_en), .mid_stb(mid_stb),
        .lvl_acq(lvl_acq), .freeze_n(freeze_n), .bt_wide(bt_wide), .rx_psave(rx_psave),
        .rx_bit(rx_bit), .pk_hi(pk_hi), .pk_lo(pk_lo)
    );

    typedef struct { longint hi; longint lo; bit d; string tag; } exp_t;
    exp_t exp_q[$];
    int   checks = 0, errors = 0;
    bit   done = 1'b0;

    // model state
    longint m_hi = 0, m_lo = 0;
    bit     m_prev = 0, m_d = 0, m_acq_q = 0;
    int     m_cnt = 0;

    function automatic longint trk(longint r, longint s, bit pos, int md, bit en, bit stb);
        longint e = s - r;
        bit     bey = pos ? (e > 0) : (e < 0);
        case (md)
            0: return en ? r + (((s >>> 1) - r) >>> 2) : r;
            1: return (en && bey) ? r + (e >>> 2) : r;
            2: return !en ? r : (bey ? r + (e >>> 6) : r - (r >>> 10));
            default: return stb ? r - (r >>> 11) : r;
        endcase
    endfunction

    task automatic drive(input int s, input bit en, input bit stb, input bit acq,
                         input bit frz, input bit bw, input bit ps, input bit rst,
                         input string tag);
        exp_t   x;
        longint se, mid, isi, lvl;
        int     md;
        bit     rise, raw;
        @(negedge clk);
        smp = SW'(s); smp_en = en; mid_stb = stb; lvl_acq = acq;
        freeze_n = frz; bt_wide = bw; rx_psave = ps; rst_n = !rst;
        if (rst) begin
            m_hi = 0; m_lo = 0; m_prev = 0; m_d = 0; m_acq_q = 0; m_cnt = 0;
        end else begin
            se   = longint'(s) <<< FRAC;
            rise = acq && !m_acq_q;
            if (acq) md = (rise || m_cnt != 0) ? 0 : 1;   // R2 clamp, R3 fast, R6
            else     md = frz ? 2 : 3;                    // R4 averaging, R5 hold
            mid = (m_hi + m_lo) >>> 1;                    // R7 level
            isi = bw ? ((m_hi - m_lo) >>> 4) : ((m_hi - m_lo) >>> 3);
            lvl = m_prev ? mid - isi : mid + isi;
            raw = (se < lvl);                             // R8 polarity
            if (ps) m_d = 0;                              // R9
            else if (stb && en) m_d = raw;
            if (stb && en) m_prev = raw;
            m_hi = trk(m_hi, se, 1'b1, md, en, stb);
            m_lo = trk(m_lo, se, 1'b0, md, en, stb);
            if (!acq) m_cnt = 0;
            else if (rise) m_cnt = en ? SPB - 1 : SPB;
            else if (en && m_cnt != 0) m_cnt--;
            m_acq_q = acq;
        end
        x.hi = m_hi >>> FRAC; x.lo = m_lo >>> FRAC; x.d = m_d; x.tag = tag;
        exp_q.push_back(x);
    endtask

    // monitor: compare one expected item after each rising edge
    always @(posedge clk) begin
        exp_t x;
        #1;
        if (exp_q.size() > 0) begin
            x = exp_q.pop_front();
            checks += 3;
            if ($signed(pk_hi) != x.hi) begin
                errors++;
                $display("FAIL %s/R10 pk_hi got %0d exp %0d", x.tag, $signed(pk_hi), x.hi);
            end
            if ($signed(pk_lo) != x.lo) begin
                errors++;
                $display("FAIL %s/R10 pk_lo got %0d exp %0d", x.tag, $signed(pk_lo), x.lo);
            end
            if (rx_bit != x.d) begin
                errors++;
                $display("FAIL %s rx_bit got %0d exp %0d", x.tag, rx_bit, x.d);
            end
        end
    end

    // one bit of SPB samples, level by data (1 = negative), strobe at sample 3
    task automatic send_bit(input bit b, input int amp, input int dc, input int noise,
                            input bit acq, input bit frz, input bit bw, input bit ps,
                            input string tag);
        for (int k = 0; k < SPB; k++) begin
            int v = (b ? -amp : amp) + dc;
            if (noise > 0) v += int'($urandom_range(2 * noise)) - noise;
            if (k == 0 || k == SPB - 1) v = v / 2 + dc / 2;
            drive(v, 1'b1, k == 3, acq, frz, bw, ps, 1'b0, tag);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) drive(300, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
        // R2: clamp toward half the input on an acquire rise, then R3 fast
        for (int i = 0; i < 12; i++)
            drive(900, 1'b1, i == 3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        // R3, R7, R8: fast peaks on a 1100 pattern with offset, narrow ISI
        for (int i = 0; i < 40; i++)
            send_bit(((i >> 1) & 1) == 0, 1000, 120, 60, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
        // R6: freeze_n low during acquire must not stop tracking
        for (int i = 0; i < 16; i++)
            send_bit(i % 3 == 0, 1400, -80, 90, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        // R4, R7: averaging, wide ISI, random data near the level
        for (int i = 0; i < 60; i++)
            send_bit($urandom_range(1) == 1, 700, 40, 300, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
        // R8: small excursions around the level with narrow ISI
        for (int i = 0; i < 30; i++)
            send_bit($urandom_range(1) == 1, 150, 0, 200, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
        // R5: hold, slow leak once per bit, data still sliced
        for (int i = 0; i < 60; i++)
            send_bit(i % 2 == 1, 500, 0, 400, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        // R5: hold with gaps in sample enable and strobes
        for (int i = 0; i < 20; i++)
            drive(-1500, i % 3 == 0, i % 5 == 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        // R9: powersave forces data to 0 while history keeps updating
        for (int i = 0; i < 20; i++)
            send_bit(1'b1, 900, 0, 100, 1'b0, 1'b1, 1'b0, 1'b1, "R9");
        for (int i = 0; i < 10; i++)
            send_bit(i % 2 == 0, 900, 0, 100, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
        // R2: second acquire rise with a large negative level, mid-bit enable gaps
        for (int i = 0; i < 6; i++)
            drive(-1800, i != 2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        for (int i = 0; i < 10; i++)
            drive(-1800, 1'b1, i == 4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        for (int i = 0; i < 10; i++)
            send_bit(i % 2 == 0, 1800, 0, 50, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
        // R1: reset in the middle of operation
        drive(500, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
        drive(500, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule